// File: doc/BRIEF.md
# Load String Word Sequencer

This block carries out a multi-cycle "load string word" operation for a processor pipeline. A start pulse hands it a destination register index, the indices of the base and index registers, the base register's value, an index value, a byte count and two mode bits. The count comes either from a 5-bit immediate field or from a count register. The block fetches one byte per cycle through a byte-read port with one cycle of latency. It packs the bytes into 32-bit words, first byte most significant, and writes each word into the low half of a 64-bit general register through a write port.

The destination index counts up from the starting register and wraps from 31 to 0. A final partial word is padded with zero bytes. A register that holds the base or the index operand is stepped over without being written. Decode, the register file and the memory sit outside the block. The block signals completion with a one-cycle done pulse. In little-endian mode it does not run and instead raises a one-cycle alignment exception request.

Top module: `strload_seq`

## Requirements
- R1: The first byte address is index_val plus base_val. When ra_idx is 0, a zero base is used in place of base_val.
- R2: When form_idx is 0, the byte count is imm_nb, and imm_nb of 0 means 32 bytes. When form_idx is 1, the byte count is cnt_reg.
- R3: For a count of n bytes, ceil(n/4) destination slots are visited. They start at rt_idx and run through consecutive indices, wrapping from 31 to 0.
- R4: Each written word sits in wr_data[31:0]. The byte fetched first occupies bits 31:24, so bytes 01,02,03,04 give 0x01020304. wr_data[63:32] is zero.
- R5: The unfetched low bytes of a final partial word are zero, so a 3-byte load of 01,02,03 writes 0x01020300.
- R6: Exactly as many writes occur as there are unprotected visited slots. No register outside the visited slots is written.
- R7: A slot equal to a nonzero ra_idx is not written, and in the indexed form a slot equal to rb_idx is not written either. The sequence still moves past such a slot. In the immediate form, rb_idx protects nothing.
- R8: With little_end set, a start produces no memory reads, no writes and no done. Instead align_exc is high for exactly the one cycle after the start.
- R9: In the indexed form with cnt_reg of 0, no reads and no writes occur, and done pulses in the cycle after the start.
- R10: mem_rd issues one byte per cycle with mem_addr rising by one each cycle. mem_rdata is taken one cycle after the matching request.
- R11: busy is high from the cycle after an accepted start through the done cycle. done lasts one cycle. A start pulse while busy is high is ignored. After reset, busy, done, align_exc, mem_rd and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| form_idx | input | 1 | 1: indexed form (count register), 0: immediate form |
| little_end | input | 1 | Little-endian mode; the operation is refused |
| rt_idx | input | 5 | First destination register index |
| ra_idx | input | 5 | Base register index (0 means zero base) |
| rb_idx | input | 5 | Index register index (protected in indexed form) |
| base_val | input | 64 | Value of the base register |
| index_val | input | 64 | Index value added to the base |
| imm_nb | input | 5 | Immediate byte count, 0 means 32 |
| cnt_reg | input | 7 | Byte count for the indexed form |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 64 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 5 | Register write index |
| wr_data | output | 64 | Register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| align_exc | output | 1 | One-cycle alignment exception request |

## Verification
The last packed word and the done pulse leave the block in the same cycle, so the final register write and completion always coincide. The bench checks that the write seen in that cycle is counted and carries the right data. It also provokes the harder overlap, where the final slot is protected: done must then pulse in a cycle where wr_en stays low. One vector ends its wrap on the base register, so that register must keep its sentinel value while the write count still matches the unprotected slots. A second start pulse placed mid-run tests that the busy guard overlaps correctly with an active sequence.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lsw_addr_gen.sv
module lsw_addr_gen #(
   parameter int AW    = 64,
   parameter int TOT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    ea,
   input  logic [TOT_W-1:0] total,
   output logic             mem_rd,
   output logic [AW-1:0]    mem_addr,
   output logic             byte_vld
);

   logic [AW-1:0]    addr_q;
   logic [TOT_W-1:0] left_q;
   logic             vld_q;

   assign mem_rd   = (left_q != '0);
   assign mem_addr = addr_q;
   assign byte_vld = vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= mem_rd;
         if (load) begin
            addr_q <= ea;
            left_q <= total;
         end else if (mem_rd) begin
            addr_q <= addr_q + AW'(1);
            left_q <= left_q - TOT_W'(1);
         end
      end
   end

endmodule

// File: rtl/lsw_packer.sv
module lsw_packer #(
   parameter int WORD_W = 32,
   parameter int TOT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TOT_W-1:0]  total,
   input  logic              byte_vld,
   input  logic [7:0]        byte_in,
   output logic              emit,
   output logic [WORD_W-1:0] emit_word,
   output logic              emit_last
);

   localparam int WB    = WORD_W / 8;
   localparam int POS_W = (WB > 1) ? $clog2(WB) : 1;

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_nx;
   logic [POS_W-1:0]  pos_q;
   logic [TOT_W-1:0]  got_q;
   logic [TOT_W-1:0]  got_nx;
   logic [TOT_W-1:0]  tot_q;
   logic              emit_q;
   logic              last_q;
   logic [WORD_W-1:0] eword_q;
   logic              fin;
   logic              full;

   always_comb begin
      word_nx = word_q;
      for (int b = 0; b < WB; b++) begin
         if (pos_q == POS_W'(b)) begin
            word_nx[WORD_W-1-8*b -: 8] = byte_in;
         end
      end
   end

   assign got_nx = got_q + TOT_W'(1);
   assign fin    = (got_nx == tot_q);
   assign full   = (pos_q == POS_W'(WB-1));

   assign emit      = emit_q;
   assign emit_word = eword_q;
   assign emit_last = last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q  <= '0;
         pos_q   <= '0;
         got_q   <= '0;
         tot_q   <= '0;
         emit_q  <= 1'b0;
         last_q  <= 1'b0;
         eword_q <= '0;
      end else begin
         emit_q <= 1'b0;
         last_q <= 1'b0;
         if (load) begin
            word_q <= '0;
            pos_q  <= '0;
            got_q  <= '0;
            tot_q  <= total;
         end else if (byte_vld) begin
            got_q <= got_nx;
            if (full || fin) begin
               emit_q  <= 1'b1;
               last_q  <= fin;
               eword_q <= word_nx;
               word_q  <= '0;
               pos_q   <= '0;
            end else begin
               word_q <= word_nx;
               pos_q  <= pos_q + POS_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/lsw_dest_seq.sv
module lsw_dest_seq #(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32,
   parameter int RIDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [RIDX_W-1:0] rt,
   input  logic [RIDX_W-1:0] ra,
   input  logic [RIDX_W-1:0] rb,
   input  logic              indexed,
   input  logic              emit,
   input  logic [WORD_W-1:0] word,
   output logic              wr_en,
   output logic [RIDX_W-1:0] wr_idx,
   output logic [XLEN-1:0]   wr_data
);

   logic [RIDX_W-1:0] cur_q;
   logic [RIDX_W-1:0] ra_q;
   logic [RIDX_W-1:0] rb_q;
   logic              ix_q;
   logic              guard;

   assign guard  = ((ra_q != '0) && (cur_q == ra_q)) || (ix_q && (cur_q == rb_q));
   assign wr_en  = emit && !guard;
   assign wr_idx = cur_q;

   if (XLEN > WORD_W) begin : g_pad
      assign wr_data = {{(XLEN-WORD_W){1'b0}}, word};
   end else begin : g_flat
      assign wr_data = word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         ra_q  <= '0;
         rb_q  <= '0;
         ix_q  <= 1'b0;
      end else if (load) begin
         cur_q <= rt;
         ra_q  <= ra;
         rb_q  <= rb;
         ix_q  <= indexed;
      end else if (emit) begin
         cur_q <= cur_q + RIDX_W'(1);
      end
   end

endmodule

// File: rtl/strload_seq.sv
module strload_seq
   import lsw_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int AW     = 64,
   parameter int RIDX_W = 5,
   parameter int NB_W   = 5,
   parameter int CNT_W  = 7,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              form_idx,
   input  logic              little_end,
   input  logic [RIDX_W-1:0] rt_idx,
   input  logic [RIDX_W-1:0] ra_idx,
   input  logic [RIDX_W-1:0] rb_idx,
   input  logic [AW-1:0]     base_val,
   input  logic [AW-1:0]     index_val,
   input  logic [NB_W-1:0]   imm_nb,
   input  logic [CNT_W-1:0]  cnt_reg,
   output logic              mem_rd,
   output logic [AW-1:0]     mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              wr_en,
   output logic [RIDX_W-1:0] wr_idx,
   output logic [XLEN-1:0]   wr_data,
   output logic              busy,
   output logic              done,
   output logic              align_exc
);

   localparam int TOT_W = max_int(CNT_W, NB_W + 1);

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (WORD_W < 16) begin : g_small_word
      $error("WORD_W must hold at least two bytes");
   end
   if (XLEN < WORD_W) begin : g_bad_xlen
      $error("XLEN must be at least WORD_W");
   end

   seq_state_e        state_q;
   logic              accept;
   logic              go;
   logic              zero_cnt;
   logic              run_load;
   logic              zdone_q;
   logic              aexc_q;
   logic [TOT_W-1:0]  count_sel;
   logic [AW-1:0]     base_eff;
   logic [AW-1:0]     ea;
   logic              byte_vld;
   logic              pk_emit;
   logic              pk_last;
   logic [WORD_W-1:0] pk_word;

   always_comb begin
      if (form_idx) begin
         count_sel = TOT_W'(cnt_reg);
      end else if (imm_nb == '0) begin
         count_sel = TOT_W'(2**NB_W);
      end else begin
         count_sel = TOT_W'(imm_nb);
      end
   end

   assign base_eff = (ra_idx == '0) ? '0 : base_val;
   assign ea       = index_val + base_eff;

   assign busy     = (state_q == SEQ_RUN);
   assign accept   = start && !busy;
   assign go       = accept && !little_end;
   assign zero_cnt = (count_sel == '0);
   assign run_load = go && !zero_cnt;

   assign done      = zdone_q || (pk_emit && pk_last);
   assign align_exc = aexc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         zdone_q <= 1'b0;
         aexc_q  <= 1'b0;
      end else begin
         zdone_q <= go && zero_cnt;
         aexc_q  <= accept && little_end;
         case (state_q)
            SEQ_IDLE: if (go)   state_q <= SEQ_RUN;
            SEQ_RUN:  if (done) state_q <= SEQ_IDLE;
            default:            state_q <= SEQ_IDLE;
         endcase
      end
   end

   lsw_addr_gen #(
      .AW    (AW),
      .TOT_W (TOT_W)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (run_load),
      .ea       (ea),
      .total    (count_sel),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .byte_vld (byte_vld)
   );

   lsw_packer #(
      .WORD_W (WORD_W),
      .TOT_W  (TOT_W)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (run_load),
      .total     (count_sel),
      .byte_vld  (byte_vld),
      .byte_in   (mem_rdata),
      .emit      (pk_emit),
      .emit_word (pk_word),
      .emit_last (pk_last)
   );

   lsw_dest_seq #(
      .XLEN   (XLEN),
      .WORD_W (WORD_W),
      .RIDX_W (RIDX_W)
   ) u_dest (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (go),
      .rt      (rt_idx),
      .ra      (ra_idx),
      .rb      (rb_idx),
      .indexed (form_idx),
      .emit    (pk_emit),
      .word    (pk_word),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data)
   );

endmodule

// File: rtl/strload_seq_chk.sv
module strload_seq_chk #(
   parameter int XLEN   = 64,
   parameter int AW     = 64,
   parameter int WORD_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            align_exc,
   input logic            wr_en,
   input logic [XLEN-1:0] wr_data,
   input logic            mem_rd,
   input logic [AW-1:0]   mem_addr
);

   // R11
   wr_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R8
   align_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_exc |-> (!busy && !wr_en && !done && !mem_rd));

   // R4
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_data >> WORD_W) == '0));

   // R10
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

   // R10
   read_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

endmodule

bind strload_seq strload_seq_chk #(
   .XLEN   (XLEN),
   .AW     (AW),
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .align_exc (align_exc),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .mem_rd    (mem_rd),
   .mem_addr  (mem_addr)
);

// File: tb/strload_seq_bench.sv
module strload_seq_bench;

   localparam logic [63:0] SENT = 64'hDEAD_BEEF_DEAD_BEEF;

   typedef struct packed {
      logic [4:0]  rt;
      logic [4:0]  ra;
      logic [4:0]  rb;
      logic        ix;
      logic [4:0]  nb;
      logic [6:0]  cnt;
      logic [15:0] base;
      logic [15:0] off;
      logic [5:0]  nwr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{5'd11, 5'd0, 5'd3,  1'b0, 5'd3,  7'd0,   16'h0000, 16'h1000, 6'd1},
      '{5'd11, 5'd0, 5'd3,  1'b0, 5'd0,  7'd0,   16'h0000, 16'h1000, 6'd8},
      '{5'd31, 5'd0, 5'd3,  1'b0, 5'd8,  7'd0,   16'h0000, 16'h1000, 6'd2},
      '{5'd31, 5'd1, 5'd0,  1'b0, 5'd10, 7'd0,   16'h2000, 16'h0000, 6'd2},
      '{5'd11, 5'd0, 5'd5,  1'b1, 5'd0,  7'd3,   16'h0000, 16'h1000, 6'd1},
      '{5'd31, 5'd0, 5'd0,  1'b1, 5'd0,  7'd12,  16'h0000, 16'h1000, 6'd2},
      '{5'd2,  5'd4, 5'd9,  1'b1, 5'd0,  7'd7,   16'h3000, 16'h0010, 6'd2},
      '{5'd30, 5'd0, 5'd31, 1'b1, 5'd0,  7'd32,  16'h0000, 16'h1000, 6'd7},
      '{5'd0,  5'd6, 5'd0,  1'b1, 5'd0,  7'd127, 16'h0100, 16'h00F0, 6'd30},
      '{5'd5,  5'd0, 5'd0,  1'b0, 5'd31, 7'd0,   16'h0000, 16'h1004, 6'd8}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        form_idx = 1'b0;
   logic        little_end = 1'b0;
   logic [4:0]  rt_idx = '0;
   logic [4:0]  ra_idx = '0;
   logic [4:0]  rb_idx = '0;
   logic [63:0] base_val = '0;
   logic [63:0] index_val = '0;
   logic [4:0]  imm_nb = '0;
   logic [6:0]  cnt_reg = '0;
   logic        mem_rd;
   logic [63:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic [63:0] wr_data;
   logic        busy;
   logic        done;
   logic        align_exc;

   int total = 0;
   int bad = 0;

   logic [63:0] shadow  [32];
   logic [63:0] exp_reg [32];
   int          wcnt;
   int          rdcnt;
   int          exp_nwr;
   logic        first_seen;
   logic [63:0] first_addr;
   logic        have_prev;
   logic [63:0] prev_addr;
   int          addr_bad;
   logic        pend;
   logic [63:0] paddr;

   always #10 clk = ~clk;

   strload_seq u_strload_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .form_idx   (form_idx),
      .little_end (little_end),
      .rt_idx     (rt_idx),
      .ra_idx     (ra_idx),
      .rb_idx     (rb_idx),
      .base_val   (base_val),
      .index_val  (index_val),
      .imm_nb     (imm_nb),
      .cnt_reg    (cnt_reg),
      .mem_rd     (mem_rd),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .busy       (busy),
      .done       (done),
      .align_exc  (align_exc)
   );

   // memory: byte at address a is a[7:0]+1, returned one cycle after the request
   always @(negedge clk) begin
      pend  = mem_rd;
      paddr = mem_addr;
      if (wr_en) begin
         shadow[wr_idx] = wr_data;
         wcnt = wcnt + 1;
      end
      if (mem_rd) begin
         rdcnt = rdcnt + 1;
         if (!first_seen) begin
            first_seen = 1'b1;
            first_addr = mem_addr;
         end
         if (have_prev && mem_addr != prev_addr + 64'd1) addr_bad = addr_bad + 1;
         have_prev = 1'b1;
         prev_addr = mem_addr;
      end else begin
         have_prev = 1'b0;
      end
   end

   always @(posedge clk) begin
      mem_rdata <= pend ? (paddr[7:0] + 8'd1) : 8'h00;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic clear_obs();
      for (int i = 0; i < 32; i++) shadow[i] = SENT;
      wcnt = 0;
      rdcnt = 0;
      first_seen = 1'b0;
      first_addr = '0;
      have_prev = 1'b0;
      addr_bad = 0;
   endtask

   task automatic model(input vec_t v);
      int n;
      int nregs;
      logic [63:0] ea;
      ea = {48'd0, v.off} + ((v.ra == 5'd0) ? 64'd0 : {48'd0, v.base});
      n = v.ix ? int'(v.cnt) : ((v.nb == 5'd0) ? 32 : int'(v.nb));
      nregs = (n + 3) / 4;
      exp_nwr = 0;
      for (int i = 0; i < 32; i++) exp_reg[i] = SENT;
      for (int k = 0; k < nregs; k++) begin
         logic [4:0]  idx;
         logic [31:0] w;
         idx = 5'((int'(v.rt) + k) % 32);
         w = '0;
         for (int b = 0; b < 4; b++) begin
            if (4*k + b < n) begin
               logic [63:0] a;
               a = ea + 64'(4*k + b);
               w[31-8*b -: 8] = a[7:0] + 8'd1;
            end
         end
         if (!((v.ra != 5'd0 && idx == v.ra) || (v.ix && idx == v.rb))) begin
            exp_reg[idx] = {32'd0, w};
            exp_nwr = exp_nwr + 1;
         end
      end
   endtask

   task automatic drive(input vec_t v, input logic le);
      form_idx   = v.ix;
      little_end = le;
      rt_idx     = v.rt;
      ra_idx     = v.ra;
      rb_idx     = v.rb;
      base_val   = {48'd0, v.base};
      index_val  = {48'd0, v.off};
      imm_nb     = v.nb;
      cnt_reg    = v.cnt;
      start      = 1'b1;
   endtask

   task automatic wait_done(output bit seen);
      int i;
      i = 0;
      while (!done && i < 400) begin
         @(negedge clk);
         i++;
      end
      seen = done;
   endtask

   task automatic run_vec(input vec_t v, input int id);
      bit seen;
      int mism;
      logic [63:0] ea;
      clear_obs();
      model(v);
      ea = {48'd0, v.off} + ((v.ra == 5'd0) ? 64'd0 : {48'd0, v.base});
      @(negedge clk);
      drive(v, 1'b0);
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      chk(seen, "R11 done reached", 64'(seen), 64'd1);
      @(negedge clk);
      chk(!done && !busy, "R11 done single, busy released", {62'd0, done, busy}, 64'd0);
      // R6 write count, table value and model agree
      chk(wcnt == int'(v.nwr) && exp_nwr == int'(v.nwr), "R6 write count",
          64'(wcnt), 64'(v.nwr));
      // R2 number of bytes fetched
      chk(rdcnt == (v.ix ? int'(v.cnt) : ((v.nb == 5'd0) ? 32 : int'(v.nb))),
          "R2 byte count", 64'(rdcnt), 64'(v.ix ? int'(v.cnt) : ((v.nb == 5'd0) ? 32 : int'(v.nb))));
      // R3 R4 R5 R7 register contents, including untouched ones
      mism = -1;
      for (int i = 0; i < 32; i++) if (mism < 0 && shadow[i] !== exp_reg[i]) mism = i;
      if (mism < 0) chk(1'b1, "R3 R4 R5 R7 regs", 64'd0, 64'd0);
      else chk(1'b0, $sformatf("R3 R4 R5 R7 reg %0d vec %0d", mism, id), shadow[mism], exp_reg[mism]);
      // R1 effective address
      chk(first_addr == ea, "R1 first address", first_addr, ea);
      // R10 address step
      chk(addr_bad == 0, "R10 address step", 64'(addr_bad), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit seen;
      vec_t v;
      clear_obs();
      pend = 1'b0;
      paddr = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({busy, done, align_exc, mem_rd, wr_en} == 5'd0, "R11 reset outputs",
          {59'd0, busy, done, align_exc, mem_rd, wr_en}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R8 little-endian refusal
      clear_obs();
      v = '{5'd4, 5'd0, 5'd0, 1'b0, 5'd8, 7'd0, 16'h0, 16'h1000, 6'd0};
      drive(v, 1'b1);
      @(negedge clk);
      start = 1'b0;
      chk(align_exc && !busy && !done, "R8 align pulse", {61'd0, align_exc, busy, done}, 64'd4);
      @(negedge clk);
      chk(!align_exc, "R8 align one cycle", 64'(align_exc), 64'd0);
      seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (done || busy) seen = 1'b1;
      end
      chk(!seen && wcnt == 0 && rdcnt == 0, "R8 no activity", 64'(wcnt + rdcnt), 64'd0);
      little_end = 1'b0;

      // R9 indexed zero count
      clear_obs();
      v = '{5'd7, 5'd0, 5'd0, 1'b1, 5'd0, 7'd0, 16'h0, 16'h1000, 6'd0};
      drive(v, 1'b0);
      @(negedge clk);
      start = 1'b0;
      chk(done && busy, "R9 done next cycle", {62'd0, done, busy}, 64'd3);
      @(negedge clk);
      chk(!done && !busy && wcnt == 0 && rdcnt == 0, "R9 no writes",
          {62'd0, done, busy} + 64'(wcnt + rdcnt), 64'd0);

      // R11 start while busy ignored
      clear_obs();
      v = '{5'd4, 5'd0, 5'd0, 1'b0, 5'd16, 7'd0, 16'h0, 16'h1000, 6'd4};
      model(v);
      drive(v, 1'b0);
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R11 busy after start", 64'(busy), 64'd1);
      @(negedge clk);
      @(negedge clk);
      v = '{5'd20, 5'd0, 5'd0, 1'b0, 5'd4, 7'd0, 16'h0, 16'h1800, 6'd1};
      drive(v, 1'b0);
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      @(negedge clk);
      repeat (10) @(negedge clk);
      chk(seen && wcnt == 4 && shadow[20] === SENT && shadow[7] === exp_reg[7],
          "R11 busy start ignored", 64'(wcnt), 64'd4);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule